// File: doc/BRIEF.md
# Systolic Matrix-Vector Multiplier

This block multiplies two small square matrices, A and B, by one shared vector w, and returns y = A·w and z = B·w. The matrices are handled one diagonal per processing cell. The chain has 2N-1 multiply-accumulate cells for N×N matrices. Partial sums travel forward through the chain one cell per step. Vector elements travel the other way at the same rate. A per-cell coefficient selector gives each cell the entry of its diagonal that belongs to the partial sum passing through it. When no entry belongs there, the cell receives zero.

The caller first pulses `start`. It then delivers N input beats, marked by `inValid`. Beat k carries vector element w[k] together with column k of both matrices. The beat may arrive in the same cycle as `start`. The array stalls whenever the next step needs a column that has not arrived yet. The results come out as one stream with y and z interleaved: y[0], z[0], y[1], z[1], and so on. After the last result, `done` pulses once. Elements are unsigned, with a width of 2, 4 or 8 bits. The accumulators are wide enough that no sum of products can wrap.

Top module: `smv_array`

## Requirements
- R1: Every result equals the exact unsigned sum over j of M[i][j]·w[j], where M is A for y results and B for z results.
- R2: The results leave in the order y[0], z[0], y[1], z[1], …, y[N-1], z[N-1]. Each is marked by `outValid`, and when the beats are not stalled they come on consecutive cycles.
- R3: Suppose beat 0 is sampled together with `start` and the remaining beats follow on consecutive cycles. Then the last result is on `outData` 4N-2 clock edges after the edge that sampled beat 0.
- R4: `done` is high for exactly one cycle, and that cycle is the one right after the last result of a run.
- R5: Each run produces exactly 2N cycles with `outValid` high.
- R6: A gap between beats stalls the whole array until the missing column arrives. Values and order are unchanged. For N=2, the last result appears at edge max(6, b1+4), counted from the beat-0 edge, where b1 is the edge that samples beat 1.
- R7: Beats outside a run, and beats after the N-th beat of a run, are ignored. They produce no output and do not change any result.
- R8: A synchronous active-high reset clears `outValid`, `done` and `outData` to zero.
- R9: When every operand is at full scale (all ones), the results are still exact. The accumulator width is 2·EL_W + clog2(N) + 1.
- R10: A `start` during a run drops that run. Only the new run's 2N results follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new run (restarts one in progress) |
| inValid | input | 1 | Marks an input beat |
| vecIn | input | EL_W | Vector element w[k] of beat k |
| coefIn | input | 2·N·N·EL_W | Column k of both matrices; entry (mat, i) at bit offset (mat·N+i)·EL_W, mat 0 = A, 1 = B |
| outValid | output | 1 | A result is on outData |
| outData | output | 2·EL_W+clog2(N)+1 | Result value |
| done | output | 1 | One-cycle pulse after the last result |

## Verification
The assertions watch the completion protocol on every cycle. They check that `done` follows a result, lasts one cycle and never overlaps a result. They check that a run never produces more than 2N results and that `done` comes only after all 2N. They also check that outputs are clear after reset. The arithmetic is checked only by the bench scenarios: correctness of each sum, the y/z interleave, the exact latency, stall timing with gapped beats, rejection of stray and extra beats, and restart. For those, the bench compares the captured stream against values it computes itself, using random and full-scale operands.

// File: rtl/smv_pkg.sv
`timescale 1ns / 1ps
package smv_pkg;
  localparam int STEP_W = 8;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic              advance;  // move every pipeline register one step
    logic [STEP_W-1:0] step;     // current array step
    logic              loadEn;   // capture a column and vector element
    logic [STEP_W-1:0] loadIdx;  // column index of the captured beat
  } smv_ctrl_t;
endpackage

// File: rtl/smv_cell.sv
`timescale 1ns / 1ps
module smv_cell #(
  parameter int EL_W  = 2,
  parameter int ACC_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [EL_W-1:0]  coef,
  input  logic [EL_W-1:0]  vecIn,
  input  logic [ACC_W-1:0] psumIn,
  output logic [ACC_W-1:0] psumOut
);
  logic [2*EL_W-1:0] prod;

  always_comb prod = coef * vecIn;

  always_ff @(posedge clk) begin
    if (rst)     psumOut <= '0;
    else if (en) psumOut <= psumIn + ACC_W'(prod);
  end
endmodule

// File: rtl/smv_ctrl.sv
`timescale 1ns / 1ps
module smv_ctrl
  import smv_pkg::*;
#(
  parameter int N = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       inValid,
  output smv_ctrl_t  ctl,
  output logic       outValid,
  output logic       done
);
  localparam int NCELL     = 2 * N - 1;
  localparam int NRES      = 2 * N;
  localparam int FIRST_OUT = NCELL - 1;
  localparam int LAST_STEP = NCELL - 1 + NRES - 1;

  logic              running;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] cnt;
  logic              lastQ;
  logic              advance;
  logic              loadEn;

  // highest column index the array reads at step s
  function automatic int needCol(int s);
    int a, b, r;
    a = s / 2;
    b = s - N + 1;
    r = (a > b) ? a : b;
    if (r > N - 1) r = N - 1;
    if (r < 0)     r = 0;
    return r;
  endfunction

  always_comb begin
    advance = running && !start && (int'(cnt) > needCol(int'(step)));
    loadEn  = inValid && (start || (running && (cnt < STEP_W'(N))));
    ctl.advance = advance;
    ctl.step    = step;
    ctl.loadEn  = loadEn;
    ctl.loadIdx = start ? '0 : cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      step     <= '0;
      cnt      <= '0;
      outValid <= 1'b0;
      lastQ    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done     <= lastQ;
      outValid <= 1'b0;
      lastQ    <= 1'b0;
      if (start) begin
        running <= 1'b1;
        step    <= '0;
        cnt     <= inValid ? STEP_W'(1) : '0;
      end else begin
        if (loadEn) cnt <= cnt + STEP_W'(1);
        if (advance) begin
          step     <= step + STEP_W'(1);
          outValid <= (step >= STEP_W'(FIRST_OUT));
          lastQ    <= (step == STEP_W'(LAST_STEP));
          if (step == STEP_W'(LAST_STEP)) running <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/smv_datapath.sv
`timescale 1ns / 1ps
module smv_datapath
  import smv_pkg::*;
#(
  parameter int N     = 2,
  parameter int EL_W  = 2,
  parameter int ACC_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  smv_ctrl_t             ctl,
  input  logic [EL_W-1:0]       vecIn,
  input  logic [2*N*N*EL_W-1:0] coefIn,
  output logic [ACC_W-1:0]      outData
);
  localparam int NCELL = 2 * N - 1;

  logic [EL_W-1:0]  coefMem [2][N][N];  // [matrix][row][column]
  logic [EL_W-1:0]  vecMem  [N];
  logic [EL_W-1:0]  vecFeed;
  logic [EL_W-1:0]  vecPipe [NCELL-1];  // vector seen by cell d, d < NCELL-1
  logic [EL_W-1:0]  vecAt   [NCELL];
  logic [EL_W-1:0]  coefAt  [NCELL];
  logic [ACC_W-1:0] psumQ   [NCELL];

  // column store
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N; k++) begin
        vecMem[k] <= '0;
        for (int m = 0; m < 2; m++)
          for (int i = 0; i < N; i++) coefMem[m][i][k] <= '0;
      end
    end else if (ctl.loadEn) begin
      for (int k = 0; k < N; k++) begin
        if (ctl.loadIdx == STEP_W'(k)) begin
          vecMem[k] <= vecIn;
          for (int m = 0; m < 2; m++)
            for (int i = 0; i < N; i++)
              coefMem[m][i][k] <= coefIn[(m*N+i)*EL_W +: EL_W];
        end
      end
    end
  end

  // vector element k enters the far end at steps 2k and 2k+1
  always_comb begin
    vecFeed = '0;
    for (int k = 0; k < N; k++)
      if ((ctl.step >> 1) == STEP_W'(k)) vecFeed = vecMem[k];
  end

  // vector flows from the last cell toward cell 0
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int d = 0; d < NCELL - 1; d++) vecPipe[d] <= '0;
    end else if (ctl.advance) begin
      for (int d = 0; d < NCELL - 2; d++) vecPipe[d] <= vecPipe[d+1];
      vecPipe[NCELL-2] <= vecFeed;
    end
  end

  genvar d;
  generate
    for (d = 0; d < NCELL; d++) begin : g_cell
      if (d == NCELL - 1) begin : g_far
        always_comb vecAt[d] = vecFeed;
      end else begin : g_near
        always_comb vecAt[d] = vecPipe[d];
      end

      // the partial sum in cell d at step s is result slot m = s - d
      always_comb begin
        int m, row, col, mat;
        coefAt[d] = '0;
        m   = int'(ctl.step) - d;
        row = m / 2;
        mat = m % 2;
        col = row + d - N + 1;
        for (int a = 0; a < 2; a++)
          for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
              if (m >= 0 && m < 2 * N && mat == a && row == i && col == j)
                coefAt[d] = coefMem[a][i][j];
      end

      if (d == 0) begin : g_head
        smv_cell #(.EL_W(EL_W), .ACC_W(ACC_W)) u_cell (
          .clk(clk), .rst(rst), .en(ctl.advance),
          .coef(coefAt[d]), .vecIn(vecAt[d]),
          .psumIn('0), .psumOut(psumQ[d])
        );
      end else begin : g_body
        smv_cell #(.EL_W(EL_W), .ACC_W(ACC_W)) u_cell (
          .clk(clk), .rst(rst), .en(ctl.advance),
          .coef(coefAt[d]), .vecIn(vecAt[d]),
          .psumIn(psumQ[d-1]), .psumOut(psumQ[d])
        );
      end
    end
  endgenerate

  assign outData = psumQ[NCELL-1];
endmodule

// File: rtl/smv_array.sv
`timescale 1ns / 1ps
module smv_array
  import smv_pkg::*;
#(
  parameter int N     = 2,
  parameter int EL_W  = 2,
  localparam int ACC_W = 2 * EL_W + $clog2(N) + 1,
  localparam int CW    = 2 * N * N * EL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             inValid,
  input  logic [EL_W-1:0]  vecIn,
  input  logic [CW-1:0]    coefIn,
  output logic             outValid,
  output logic [ACC_W-1:0] outData,
  output logic             done
);
  generate
    if (EL_W != 2 && EL_W != 4 && EL_W != 8) begin : g_bad_width
      $error("smv_array: EL_W must be 2, 4 or 8");
    end
    if (N < 2) begin : g_bad_size
      $error("smv_array: N must be at least 2");
    end
  endgenerate

  smv_ctrl_t ctl;

  smv_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .inValid(inValid),
    .ctl(ctl), .outValid(outValid), .done(done)
  );

  smv_datapath #(.N(N), .EL_W(EL_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .vecIn(vecIn), .coefIn(coefIn), .outData(outData)
  );
endmodule

// File: rtl/smv_array_chk.sv
`timescale 1ns / 1ps
module smv_array_chk #(
  parameter int N = 2
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic outValid,
  input logic done
);
  logic       rstD;
  logic [7:0] outCnt;

  always_ff @(posedge clk) begin
    rstD <= rst;
    if (rst || start) outCnt <= '0;
    else if (outValid) outCnt <= outCnt + 8'd1;
  end

  // R8
  always_ff @(posedge clk) begin
    if (rstD) begin
      reset_clear_chk: assert (!outValid && !done);
    end
  end

  // R4
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(outValid));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  done_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !outValid);

  // R5
  result_count_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (int'(outCnt) < 2 * N));

  // R5
  done_total_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(start)) |-> (int'(outCnt) == 2 * N));
endmodule

bind smv_array smv_array_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .start(start), .outValid(outValid), .done(done)
);

// File: tb/test_smv_array.sv
`timescale 1ns / 1ps
module test_smv_array;
  localparam int N     = 2;
  localparam int EL_W  = 2;
  localparam int ACC_W = 2 * EL_W + $clog2(N) + 1;
  localparam int CW    = 2 * N * N * EL_W;
  localparam int MAXC  = 48;
  localparam int EMAX  = (1 << EL_W) - 1;

  logic             clk = 1'b0;
  logic             rst, start, inValid;
  logic [EL_W-1:0]  vecIn;
  logic [CW-1:0]    coefIn;
  logic             outValid;
  logic [ACC_W-1:0] outData;
  logic             done;

  always #2.5 clk = ~clk;

  smv_array #(.N(N), .EL_W(EL_W)) i_smv_array (
    .clk(clk), .rst(rst), .start(start), .inValid(inValid),
    .vecIn(vecIn), .coefIn(coefIn),
    .outValid(outValid), .outData(outData), .done(done)
  );

  int errors = 0;
  int checks = 0;
  int mats [2][N][N];
  int vecs [N];

  logic            stS   [MAXC];
  logic            stV   [MAXC];
  logic [EL_W-1:0] stVec [MAXC];
  logic [CW-1:0]   stCoef[MAXC];

  int outVals[16];
  int outCycs[16];
  int nOut, nDone, doneCyc;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expRes(int k);
    int s = 0;
    for (int j = 0; j < N; j++) s += mats[k % 2][k / 2][j] * vecs[j];
    return s;
  endfunction

  function automatic logic [CW-1:0] packCol(int k);
    logic [CW-1:0] c = '0;
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < N; i++)
        c[(m*N+i)*EL_W +: EL_W] = EL_W'(mats[m][i][k]);
    return c;
  endfunction

  task automatic clearStim();
    for (int c = 0; c < MAXC; c++) begin
      stS[c] = 0; stV[c] = 0; stVec[c] = '0; stCoef[c] = '0;
    end
  endtask

  task automatic beatAt(int cyc, int k, bit withStart);
    stV[cyc]    = 1'b1;
    stVec[cyc]  = EL_W'(vecs[k]);
    stCoef[cyc] = packCol(k);
    if (withStart) stS[cyc] = 1'b1;
  endtask

  task automatic randData();
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) mats[m][i][j] = int'($urandom_range(EMAX, 0));
    for (int j = 0; j < N; j++) vecs[j] = int'($urandom_range(EMAX, 0));
  endtask

  // we sit at a negedge on entry and exit
  task automatic runStim(int ncyc);
    nOut = 0; nDone = 0; doneCyc = -1;
    for (int c = 0; c < ncyc; c++) begin
      if (outValid === 1'b1 && nOut < 16) begin
        outVals[nOut] = int'(outData);
        outCycs[nOut] = c;
        nOut++;
      end
      if (done === 1'b1) begin
        nDone++;
        doneCyc = c;
      end
      if (c < MAXC) begin
        start = stS[c]; inValid = stV[c]; vecIn = stVec[c]; coefIn = stCoef[c];
      end else begin
        start = 0; inValid = 0; vecIn = '0; coefIn = '0;
      end
      @(posedge clk);
      @(negedge clk);
    end
    start = 0; inValid = 0;
  endtask

  task automatic checkRun(string tag, int lastExp);
    check(nOut == 2 * N, "R5", {tag, " result count"}, nOut, 2 * N);
    for (int k = 0; k < nOut && k < 2 * N; k++) begin
      check(outVals[k] == expRes(k), "R1", {tag, " result value"}, outVals[k], expRes(k));
      check(outCycs[k] == outCycs[0] + k, "R2", {tag, " interleave slot"}, outCycs[k], outCycs[0] + k);
    end
    if (nOut > 0) begin
      check(nDone == 1, "R4", {tag, " done pulses"}, nDone, 1);
      check(doneCyc == outCycs[nOut-1] + 1, "R4", {tag, " done cycle"}, doneCyc, outCycs[nOut-1] + 1);
      if (lastExp >= 0)
        check(outCycs[nOut-1] == lastExp, "R3/R6", {tag, " last result cycle"}, outCycs[nOut-1], lastExp);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1; start = 0; inValid = 0; vecIn = '0; coefIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: outputs clear in reset
    check(outValid == 1'b0, "R8", "outValid in reset", int'(outValid), 0);
    check(done == 1'b0, "R8", "done in reset", int'(done), 0);
    check(outData == '0, "R8", "outData in reset", int'(outData), 0);
    rst = 0;
    @(negedge clk);

    // R1 R2 R3: directed, beats back to back, last result 4N-1 samples later
    mats = '{'{'{1, 2}, '{3, 0}}, '{'{2, 1}, '{0, 3}}};
    vecs = '{3, 1};
    clearStim(); beatAt(0, 0, 1); beatAt(1, 1, 0);
    runStim(20); checkRun("directed", 4 * N - 1);

    // R9: full-scale operands
    mats = '{'{'{EMAX, EMAX}, '{EMAX, EMAX}}, '{'{EMAX, EMAX}, '{EMAX, EMAX}}};
    vecs = '{EMAX, EMAX};
    clearStim(); beatAt(0, 0, 1); beatAt(1, 1, 0);
    runStim(20); checkRun("R9 fullscale", 4 * N - 1);

    // R7: beats without a run are ignored
    clearStim();
    for (int c = 0; c < 6; c++) beatAt(c, c % N, 0);
    runStim(16);
    check(nOut == 0, "R7", "outputs from stray beats", nOut, 0);
    check(nDone == 0, "R7", "done from stray beats", nDone, 0);

    // R7: an extra beat after the N-th leaves results unchanged
    mats = '{'{'{2, 0}, '{1, 3}}, '{'{0, 1}, '{3, 2}}};
    vecs = '{1, 2};
    clearStim(); beatAt(0, 0, 1); beatAt(1, 1, 0);
    stV[2] = 1; stVec[2] = '1; stCoef[2] = '1;
    runStim(20); checkRun("R7 extra beat", 4 * N - 1);

    // R6: gap before beat 1 stalls the array
    mats = '{'{'{3, 1}, '{2, 2}}, '{'{1, 3}, '{3, 1}}};
    vecs = '{2, 3};
    clearStim(); beatAt(0, 0, 1); beatAt(5, 1, 0);
    runStim(24); checkRun("R6 gap", 10);

    // R6: start alone, beats afterwards
    clearStim(); stS[0] = 1; beatAt(1, 0, 0); beatAt(2, 1, 0);
    runStim(24); checkRun("R6 late beats", 8);

    // R10: restart in the middle of a run
    mats = '{'{'{3, 3}, '{3, 3}}, '{'{3, 3}, '{3, 3}}};
    vecs = '{3, 3};
    clearStim(); beatAt(0, 0, 1); beatAt(1, 1, 0);
    mats = '{'{'{1, 0}, '{0, 1}}, '{'{0, 1}, '{1, 0}}};
    vecs = '{2, 1};
    beatAt(2, 0, 1); beatAt(3, 1, 0);
    runStim(24); checkRun("R10 restart", 2 + 4 * N - 1);

    // random runs with random gaps before beat 1
    for (int r = 0; r < 40; r++) begin
      int gap, b1, lastE;
      randData();
      gap = int'($urandom_range(4, 0));
      b1  = 1 + gap;
      lastE = (b1 + 5 > 7) ? b1 + 5 : 7;
      clearStim(); beatAt(0, 0, 1); beatAt(b1, 1, 0);
      runStim(24); checkRun("random", lastE);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule